// File: doc/BRIEF.md
# Signed Divider with Truncated and Floored Remainders

This unit divides one two's-complement integer by another and returns three answers at once: a quotient rounded toward zero, a remainder whose sign follows the dividend (truncated remainder), and a remainder whose sign follows the divisor (floored remainder, or modulo). Operands are taken on a start pulse while the unit is idle. The unit then reports busy, runs one restoring step per operand bit on the operand magnitudes, spends one cycle on sign correction, and pulses done with every result valid.

A zero divisor is caught at acceptance. The unit skips the iteration, reports it through a flag and returns zeros after a short fixed latency. The one quotient that does not fit the operand width, the most negative value divided by minus one, is flagged as an overflow. Results and flags are held until the next operation completes.

Top module: `sdiv_remmod`

## Requirements
- R1: For a non-zero divisor the quotient is A/B rounded toward zero, so that A = quot*B + rem holds exactly.
- R2: The truncated remainder rem is zero or has the sign of A, and its magnitude is below |B|.
- R3: The floored remainder mod is zero or has the sign of B, and its magnitude is below |B|. It equals rem when rem is zero or when rem and B share a sign, and equals rem + B otherwise.
- R4: The four sign cases of 5 and 3 give: (5,3) rem 2 mod 2; (-5,3) rem -2 mod 1; (5,-3) rem 2 mod -1; (-5,-3) rem -2 mod -2. The quotients are 1, -1, -1 and 1.
- R5: For a non-zero divisor, done is high for exactly one cycle and rises WIDTH+1 rising clock edges after the edge that accepts start.
- R6: busy rises on the edge that accepts start (start high while busy is low) and stays high until done. A start pulse while busy is ignored and does not change the running operation's results.
- R7: A zero divisor sets dbz, forces quot, rem and mod to zero and brings done one edge after the accepting edge. dbz is cleared by the next operation with a non-zero divisor.
- R8: The most negative value divided by -1 sets ovf, returns the most negative value as quotient (wrapped), and returns zero for rem and mod. No other operand pair sets ovf.
- R9: The most negative dividend and the most negative divisor give correct results with every other operand.
- R10: The synchronous active-low reset returns the unit to idle and clears busy, done, dbz, ovf and all three results to zero, also in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin an operation; accepted only while busy is low |
| a | input | WIDTH | Dividend, two's complement |
| b | input | WIDTH | Divisor, two's complement |
| busy | output | 1 | An accepted operation is in progress |
| done | output | 1 | One-cycle pulse: results and flags are valid |
| quot | output | WIDTH | Quotient rounded toward zero |
| rem_o | output | WIDTH | Remainder with the sign of the dividend |
| mod_o | output | WIDTH | Remainder with the sign of the divisor |
| dbz | output | 1 | Last completed operation had a zero divisor |
| ovf | output | 1 | Last completed operation overflowed the quotient |

## Verification
The hardest case to reach is the floored correction path meeting the range edges: remainders whose sign disagrees with the divisor while one operand is the most negative value, which random operands rarely produce. The stimulus lists those pairs directly (most negative over small and large divisors of both signs, any value over the most negative divisor, and the single overflowing pair) before a long pseudo-random run. A start pulse with different operands is injected in the middle of some operations so that the scoreboard shows that the running result is unaffected, and a reset is issued during an operation to prove the unit recovers.

// File: rtl/sdiv_pkg.sv
// Package: shared types of the signed divider.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sdiv_pkg;

    // Controller phases of one division.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2,
        ST_ZERO = 2'd3
    } sdiv_state_e;

endpackage

// File: rtl/sdiv_prep.sv
// Module: sdiv_prep
// Splits the raw operands into signs and unsigned magnitudes and spots the
// two special operand classes (zero divisor, quotient overflow).
// Assumes WIDTH >= 2. Purely combinational.
module sdiv_prep #(
    parameter int WIDTH = 8,
    localparam int MW = WIDTH + 1
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             sign_a,
    output logic             sign_b,
    output logic [WIDTH-1:0] mag_a,
    output logic [MW-1:0]    mag_b,
    output logic             b_is_zero,
    output logic             q_overflow
);

    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    logic [MW-1:0] b_ext;

    // Magnitudes: a fits WIDTH unsigned bits even at its most negative value.
    always_comb begin
        sign_a     = a[WIDTH-1];
        sign_b     = b[WIDTH-1];
        mag_a      = sign_a ? (~a + 1'b1) : a;
        b_ext      = {b[WIDTH-1], b};
        mag_b      = sign_b ? (~b_ext + 1'b1) : b_ext;
        b_is_zero  = (b == '0);
        q_overflow = (a == MOST_NEG) && (b == '1);
    end

endmodule

// File: rtl/sdiv_ctrl.sv
// Module: sdiv_ctrl
// Sequences one division: accepts start while idle, counts WIDTH iteration
// cycles, then one correction cycle; a zero divisor takes a one-cycle path.
// Assumes start is sampled only while idle; start during busy is ignored.
module sdiv_ctrl
    import sdiv_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int CW = $clog2(WIDTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic b_is_zero,
    output logic accept,
    output logic step,
    output logic finish,
    output logic busy
);

    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    sdiv_state_e   state;
    logic [CW-1:0] cnt;

    // Phase register and iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start) state <= b_is_zero ? ST_ZERO : ST_ITER;
                end
                ST_ITER: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) state <= ST_FIX;
                end
                ST_FIX:  state <= ST_IDLE;
                ST_ZERO: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decoded strobes for the datapath.
    always_comb begin
        accept = (state == ST_IDLE) && start;
        step   = (state == ST_ITER);
        finish = (state == ST_FIX) || (state == ST_ZERO);
        busy   = (state != ST_IDLE);
    end

endmodule

// File: rtl/sdiv_core.sv
// Module: sdiv_core
// Restoring unsigned division of magnitudes, one quotient bit per step.
// Assumes mag_b is non-zero when steps run; result valid after WIDTH steps.
module sdiv_core #(
    parameter int WIDTH = 8,
    localparam int MW = WIDTH + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] mag_a,
    input  logic [MW-1:0]    mag_b,
    output logic [WIDTH-1:0] q_mag,
    output logic [WIDTH-1:0] r_mag
);

    logic [MW-1:0]    part;
    logic [MW-1:0]    dvsr;
    logic [WIDTH-1:0] qsh;
    logic [MW-1:0]    trial;
    logic             fits;

    // Trial subtraction of the shifted partial remainder.
    always_comb begin
        trial = {part[MW-2:0], qsh[WIDTH-1]};
        fits  = (trial >= dvsr);
    end

    // Partial remainder, divisor and quotient shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part <= '0;
            dvsr <= '0;
            qsh  <= '0;
        end else if (load) begin
            part <= '0;
            dvsr <= mag_b;
            qsh  <= mag_a;
        end else if (step) begin
            part <= fits ? (trial - dvsr) : trial;
            qsh  <= {qsh[WIDTH-2:0], fits};
        end
    end

    assign q_mag = qsh;
    assign r_mag = part[WIDTH-1:0];

endmodule

// File: rtl/sdiv_fix.sv
// Module: sdiv_fix
// Applies signs to the magnitude results and derives the floored remainder
// from the truncated one by a conditional add of the divisor.
// Assumes r_mag < |b|. Purely combinational.
module sdiv_fix #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] q_mag,
    input  logic [WIDTH-1:0] r_mag,
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] q_out,
    output logic [WIDTH-1:0] r_out,
    output logic [WIDTH-1:0] m_out
);

    logic r_nz;

    // Sign correction and floored adjustment.
    always_comb begin
        q_out = (sign_a ^ sign_b) ? (~q_mag + 1'b1) : q_mag;
        r_out = sign_a ? (~r_mag + 1'b1) : r_mag;
        r_nz  = (r_mag != '0);
        m_out = (r_nz && (sign_a != sign_b)) ? (r_out + b) : r_out;
    end

endmodule

// File: rtl/sdiv_remmod.sv
// Module: sdiv_remmod (top)
// Sequential signed divider returning quotient, truncated remainder and
// floored remainder, with zero-divisor and overflow flags.
// Assumes a and b are stable on the accepting edge only; results and flags
// hold from done until the next completion. Synchronous active-low reset.
module sdiv_remmod #(
    parameter int WIDTH = 8,
    localparam int MW = WIDTH + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quot,
    output logic [WIDTH-1:0] rem_o,
    output logic [WIDTH-1:0] mod_o,
    output logic             dbz,
    output logic             ovf
);

    logic             sign_a, sign_b, b_is_zero, q_overflow;
    logic [WIDTH-1:0] mag_a;
    logic [MW-1:0]    mag_b;
    logic             accept, step, finish;
    logic [WIDTH-1:0] q_mag, r_mag;
    logic [WIDTH-1:0] q_fix, r_fix, m_fix;

    logic             sa_q, sb_q, bz_q, ov_q;
    logic [WIDTH-1:0] b_q;

    sdiv_prep #(.WIDTH(WIDTH)) u_prep (
        .a(a), .b(b),
        .sign_a(sign_a), .sign_b(sign_b),
        .mag_a(mag_a), .mag_b(mag_b),
        .b_is_zero(b_is_zero), .q_overflow(q_overflow)
    );

    sdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .b_is_zero(b_is_zero),
        .accept(accept), .step(step), .finish(finish), .busy(busy)
    );

    sdiv_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .load(accept), .step(step),
        .mag_a(mag_a), .mag_b(mag_b),
        .q_mag(q_mag), .r_mag(r_mag)
    );

    sdiv_fix #(.WIDTH(WIDTH)) u_fix (
        .q_mag(q_mag), .r_mag(r_mag),
        .sign_a(sa_q), .sign_b(sb_q), .b(b_q),
        .q_out(q_fix), .r_out(r_fix), .m_out(m_fix)
    );

    // Operand signs, divisor and special-case marks kept for the fix-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa_q <= 1'b0;
            sb_q <= 1'b0;
            bz_q <= 1'b0;
            ov_q <= 1'b0;
            b_q  <= '0;
        end else if (accept) begin
            sa_q <= sign_a;
            sb_q <= sign_b;
            bz_q <= b_is_zero;
            ov_q <= q_overflow;
            b_q  <= b;
        end
    end

    // Result registers and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            quot  <= '0;
            rem_o <= '0;
            mod_o <= '0;
            dbz   <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                if (bz_q) begin
                    quot  <= '0;
                    rem_o <= '0;
                    mod_o <= '0;
                end else begin
                    quot  <= q_fix;
                    rem_o <= r_fix;
                    mod_o <= m_fix;
                end
                dbz <= bz_q;
                ovf <= ov_q & ~bz_q;
            end
        end
    end

endmodule

// File: rtl/sdiv_remmod_chk.sv
// Module: sdiv_remmod_chk
// Property checker for sdiv_remmod, attached by bind. Keeps its own copy of
// the accepted operands to relate result signs and magnitudes to them.
module sdiv_remmod_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] quot,
    input logic [WIDTH-1:0] rem_o,
    input logic [WIDTH-1:0] mod_o,
    input logic             dbz,
    input logic             ovf
);

    logic [WIDTH-1:0] a_l, b_l;

    function automatic logic [WIDTH-1:0] mag(input logic [WIDTH-1:0] v);
        return v[WIDTH-1] ? (~v + 1'b1) : v;
    endfunction

    // Capture operands on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_l <= '0;
            b_l <= '0;
        end else if (start && !busy) begin
            a_l <= a;
            b_l <= b;
        end
    end

    // R6: busy and done never overlap.
    a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R6: an accepted start raises busy on the next cycle.
    a_r6_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5: done is a single-cycle pulse.
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: rem follows the dividend sign.
    a_r2_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dbz && rem_o != '0) |-> (rem_o[WIDTH-1] == a_l[WIDTH-1]));

    // R2: rem magnitude below divisor magnitude.
    a_r2_rem_mag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dbz) |-> (mag(rem_o) < mag(b_l)));

    // R3: mod follows the divisor sign.
    a_r3_mod_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mod_o != '0) |-> (mod_o[WIDTH-1] == b_l[WIDTH-1]));

    // R3: mod is rem or rem plus divisor.
    a_r3_mod_link: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dbz) |-> ((mod_o == rem_o) || (mod_o == rem_o + b_l)));

    // R7: zero divisor returns zeros.
    a_r7_zero_results: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dbz) |-> (quot == '0 && rem_o == '0 && mod_o == '0));

    // R8: overflow leaves both remainders zero.
    a_r8_ovf_rems: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (rem_o == '0 && mod_o == '0 && !dbz));

    // R10: reset clears the status outputs.
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !dbz && !ovf));

endmodule

bind sdiv_remmod sdiv_remmod_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
    .busy(busy), .done(done), .quot(quot), .rem_o(rem_o), .mod_o(mod_o),
    .dbz(dbz), .ovf(ovf)
);

// File: tb/sim_sdiv_remmod.sv
// Scoreboard bench for sdiv_remmod: the driver pushes expected results into a
// queue, the monitor pops and compares them on each done pulse.
module sim_sdiv_remmod;

    localparam int W = 8;

    typedef struct {
        logic [W-1:0] a, b, q, r, m;
        logic dz, ov;
        string tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] a_i = '0, b_i = '0;
    logic         busy, done, dbz, ovf;
    logic [W-1:0] quot, rem_o, mod_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    exp_t sb[$];
    logic [31:0] lcg = 32'h1234_5678;

    always #2 clk = ~clk;   // 250 MHz

    sdiv_remmod #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .a(a_i), .b(b_i),
        .busy(busy), .done(done), .quot(quot), .rem_o(rem_o), .mod_o(mod_o),
        .dbz(dbz), .ovf(ovf)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural model from integer arithmetic.
    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input string tag);
        exp_t e;
        int ai, bi, qi, ri, mi;
        ai = int'($signed(a));
        bi = int'($signed(b));
        e.a = a; e.b = b; e.tag = tag;
        if (bi == 0) begin
            e.q = '0; e.r = '0; e.m = '0; e.dz = 1'b1; e.ov = 1'b0;
        end else begin
            qi = ai / bi;
            ri = ai % bi;
            mi = (ri != 0 && ((ri < 0) != (bi < 0))) ? ri + bi : ri;
            e.q = qi[W-1:0]; e.r = ri[W-1:0]; e.m = mi[W-1:0];
            e.dz = 1'b0;
            e.ov = (qi > (2 ** (W - 1)) - 1);
        end
        return e;
    endfunction

    // Monitor: compare each completion against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R5 unexpected done: actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " R1"}, "quot", quot, e.q);
                chk({e.tag, " R2"}, "rem", rem_o, e.r);
                chk({e.tag, " R3"}, "mod", mod_o, e.m);
                chk({e.tag, " R7"}, "dbz", W'(dbz), W'(e.dz));
                chk({e.tag, " R8"}, "ovf", W'(ovf), W'(e.ov));
            end
        end
    end

    // Driver: run one operation, check handshake and latency.
    task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b,
                         input string tag, input bit poke);
        int n;
        bit busy_ok;
        @(negedge clk);
        a_i = a; b_i = b; start = 1'b1;
        sb.push_back(model(a, b, tag));
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        a_i = ~a; b_i = b + 8'd1;
        n = 0;
        busy_ok = 1'b1;
        while (!done && n < 50) begin
            if (!busy) busy_ok = 1'b0;
            if (poke && n == 3) begin
                start = 1'b1; a_i = 8'h11; b_i = 8'h05;   // R6: ignored while busy
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R6", "busy during op", W'(busy_ok), W'(1));
        chk("R6", "busy at done", W'(busy), W'(0));
        chk(b == '0 ? "R7" : "R5", "latency", W'(n), b == '0 ? W'(1) : W'(W + 1));
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected 0", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10", "busy", W'(busy), W'(0));
        chk("R10", "done", W'(done), W'(0));
        chk("R10", "quot", quot, '0);
        chk("R10", "flags", W'({dbz, ovf}), W'(0));
        rst_n = 1'b1;

        // R4: sign cases
        do_op(8'd5, 8'd3, "R4", 1'b0);
        do_op(-8'sd5, 8'd3, "R4", 1'b0);
        do_op(8'd5, -8'sd3, "R4", 1'b0);
        do_op(-8'sd5, -8'sd3, "R4", 1'b0);
        do_op(8'd0, -8'sd7, "R1", 1'b0);
        do_op(8'd7, 8'd7, "R1", 1'b0);
        do_op(-8'sd6, 8'd3, "R3", 1'b0);
        // R7: zero divisor, then flag clears
        do_op(8'd42, 8'd0, "R7", 1'b0);
        do_op(8'h80, 8'd0, "R7", 1'b0);
        do_op(8'd9, 8'd2, "R7", 1'b0);
        // R8: overflow and its neighbours
        do_op(8'h80, 8'hFF, "R8", 1'b0);
        do_op(8'h81, 8'hFF, "R8", 1'b0);
        do_op(8'h80, 8'd1, "R9", 1'b0);
        // R9: extreme operands
        do_op(8'h80, 8'h80, "R9", 1'b0);
        do_op(8'h7F, 8'h80, "R9", 1'b0);
        do_op(-8'sd1, 8'h80, "R9", 1'b0);
        do_op(8'h80, 8'd3, "R9", 1'b0);
        do_op(8'h80, -8'sd3, "R9", 1'b0);
        do_op(8'h80, 8'd127, "R9", 1'b0);
        do_op(8'h7F, -8'sd128, "R9", 1'b0);
        // R6: start pulses during busy are ignored
        do_op(-8'sd100, 8'd7, "R6", 1'b1);
        do_op(8'd77, -8'sd9, "R6", 1'b1);

        // R10: reset in the middle of an operation
        @(negedge clk);
        a_i = 8'd50; b_i = 8'd3; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10", "busy after mid reset", W'(busy), W'(0));
        chk("R10", "done after mid reset", W'(done), W'(0));
        chk("R10", "rem after mid reset", rem_o, '0);
        rst_n = 1'b1;
        do_op(8'd50, 8'd3, "R10", 1'b0);

        // Pseudo-random sweep across all sign combinations
        for (int i = 0; i < 2000; i++) begin
            logic [W-1:0] ra, rb;
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            ra = lcg[23:16];
            rb = lcg[31:24];
            if (i % 4 == 1) rb = {rb[7], 5'd0, rb[1:0]};
            do_op(ra, rb, "R1", (i % 7) == 0);
        end

        repeat (4) @(negedge clk);
        chk("R5", "scoreboard empty", W'(sb.size()), W'(0));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule